// File: doc/BRIEF.md
# Card data FIFO byte engine

This block sits between a bus-side FIFO of 32-bit words and a byte-wide card data port. In the receive direction it takes bytes from the card and packs them into FIFO words. In the transmit direction it takes words out of the FIFO and sends them to the card one byte at a time. Bytes map to word lanes in little-endian order in both directions.

Software first writes a transfer length. It then writes the control strobe with the enable bit and a direction bit. The enable write loads a byte down-counter from the length. The engine moves bytes until the counter reaches zero, then flags the end of the transfer. The path disables itself once the counter is zero and the FIFO has drained. While the path is busy, the block reports one set of occupancy flags, chosen by the direction. A word-count view of the remaining bytes is also available.

Top module: `card_byte_bridge`

## Requirements
- R1: After reset, path_en, byte_cnt, word_cnt, tx_flags, rx_flags and xfer_done are all zero.
- R2: len_wr stores the LEN_W-bit len_in value. A ctl_wr with ctl_en=1 loads byte_cnt from the stored length. word_cnt always equals (byte_cnt+3)>>2.
- R3: In receive mode (ctl_rx=1), bytes are packed little-endian: the first byte goes to bits 7:0, the second to bits 15:8, the third to 23:16 and the fourth to 31:24. A final partial word is written with its unused upper bytes set to zero.
- R4: crd_in_ready is high only when the path is enabled in receive mode, byte_cnt is nonzero and the FIFO holds fewer than DEPTH words.
- R5: In transmit mode (ctl_rx=0), each FIFO word is sent little-endian, bits 7:0 first. A new word is taken only after the four bytes of the previous word have been sent. crd_out_valid stays low once byte_cnt is zero.
- R6: xfer_done rises when byte_cnt reaches zero, or when an enable write loads a length of zero. It stays high until the next enable write, which clears it when the loaded length is nonzero.
- R7: When path_en is high, byte_cnt is zero and the FIFO is empty, path_en clears on the next clock edge. In that state both flag vectors read zero.
- R8: While the path is busy, the flags of the selected direction read as follows: bit0 active, bit1 empty (occupancy 0), bit2 data available (occupancy nonzero), bit3 full (occupancy DEPTH). Bit4 is half-empty (occupancy at most DEPTH/2) for transmit, or half-full (occupancy at least DEPTH/2) for receive. The flags of the other direction read zero.
- R9: A bus push is ignored when the FIFO is full, or while a receive transfer is enabled. A bus pop is ignored when the FIFO is empty, and then pop_data reads zero.
- R10: At most one card byte moves per cycle, and each byte lowers byte_cnt by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable bit written with ctl_wr |
| ctl_rx | input | 1 | Direction written with ctl_wr (1 = card to FIFO) |
| len_wr | input | 1 | Length write strobe |
| len_in | input | LEN_W | Transfer length in bytes |
| push | input | 1 | Bus FIFO push strobe |
| push_data | input | 32 | Word to push |
| pop | input | 1 | Bus FIFO pop strobe |
| pop_data | output | 32 | Popped word, zero when the pop is ignored |
| crd_in_valid | input | 1 | Card receive byte valid |
| crd_in_data | input | 8 | Card receive byte |
| crd_in_ready | output | 1 | Engine accepts a receive byte |
| crd_out_valid | output | 1 | Transmit byte valid |
| crd_out_data | output | 8 | Transmit byte |
| crd_out_ready | input | 1 | Card accepts the transmit byte |
| path_en | output | 1 | Data path enable state |
| byte_cnt | output | LEN_W | Remaining bytes |
| word_cnt | output | LEN_W-1 | Remaining bytes in words, rounded up |
| tx_flags | output | 5 | Transmit FIFO flags |
| rx_flags | output | 5 | Receive FIFO flags |
| xfer_done | output | 1 | End of data and end of block |

## Verification
A table of receive transfers is run. Its lengths are one word short of a full word, exactly one word, one word plus a few bytes, and large enough to pass half-full. These tell correct lane packing and zero padding apart from off-by-one lane or count handling. A long receive transfer fills the FIFO, to show that ready drops at full and comes back after one pop. Transmit runs check byte order across word borders, that the engine stops at count zero with a word still queued, and that a push into a full FIFO is dropped. Zero-length and very long loads check the end flag, the self-disable and the rounding of the word count.

// File: rtl/card_byte_bridge.sv
module card_byte_bridge #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic             ctl_rx,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_in,
  input  logic             push,
  input  logic [31:0]      push_data,
  input  logic             pop,
  output logic [31:0]      pop_data,
  input  logic             crd_in_valid,
  input  logic [7:0]       crd_in_data,
  output logic             crd_in_ready,
  output logic             crd_out_valid,
  output logic [7:0]       crd_out_data,
  input  logic             crd_out_ready,
  output logic             path_en,
  output logic [LEN_W-1:0] byte_cnt,
  output logic [LEN_W-2:0] word_cnt,
  output logic [4:0]       tx_flags,
  output logic [4:0]       rx_flags,
  output logic             xfer_done
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = AW + 1;
  localparam logic [OW-1:0] FULLV = OW'(DEPTH);
  localparam logic [OW-1:0] HALFV = OW'(DEPTH / 2);

  logic [31:0]      mem [DEPTH];
  logic [AW-1:0]    rd_ptr;
  logic [OW-1:0]    occ;
  logic             en_q, rx_q, done_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic [1:0]       lane_q;
  logic [23:0]      acc_q;
  logic [31:0]      hold_q;
  logic [2:0]       hold_n;
  logic [31:0]      in_word;

  wire        full    = (occ == FULLV);
  wire        empty   = (occ == '0);
  wire        cnt_nz  = (cnt_q != '0);
  wire        cnt_one = (cnt_q == LEN_W'(1));
  wire [31:0] head    = mem[rd_ptr];
  wire        busy    = en_q & (cnt_nz | ~empty);

  assign crd_in_ready  = en_q & rx_q & cnt_nz & ~full & ~ctl_wr;
  wire   in_fire       = crd_in_valid & crd_in_ready;
  wire   last_in       = in_fire & ((lane_q == 2'd3) | cnt_one);

  assign crd_out_valid = en_q & ~rx_q & cnt_nz & ((hold_n != 3'd0) | ~empty) & ~ctl_wr;
  assign crd_out_data  = (hold_n != 3'd0) ? hold_q[7:0] : head[7:0];
  wire   out_fire      = crd_out_valid & crd_out_ready;
  wire   eng_pop       = out_fire & (hold_n == 3'd0);

  wire   bus_push_ok   = push & ~full & ~(en_q & rx_q);
  wire   bus_pop_ok    = pop & ~empty & ~eng_pop;
  wire   do_push       = bus_push_ok | last_in;
  wire   do_pop        = bus_pop_ok | eng_pop;
  wire [AW-1:0] wr_idx = rd_ptr + occ[AW-1:0];
  wire [31:0] push_word = last_in ? in_word : push_data;

  assign pop_data  = bus_pop_ok ? head : 32'd0;
  assign path_en   = en_q;
  assign byte_cnt  = cnt_q;
  assign word_cnt  = (LEN_W-1)'(({1'b0, cnt_q} + (LEN_W+1)'(3)) >> 2);
  assign xfer_done = done_q;

  assign tx_flags = (busy & ~rx_q) ? {occ <= HALFV, full, ~empty, empty, 1'b1} : 5'd0;
  assign rx_flags = (busy &  rx_q) ? {occ >= HALFV, full, ~empty, empty, 1'b1} : 5'd0;

  always_comb begin
    case (lane_q)
      2'd0:    in_word = {24'd0, crd_in_data};
      2'd1:    in_word = {16'd0, crd_in_data, acc_q[7:0]};
      2'd2:    in_word = {8'd0, crd_in_data, acc_q[15:0]};
      default: in_word = {crd_in_data, acc_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_pop) rd_ptr <= rd_ptr + AW'(1);
      occ <= occ + OW'(do_push) - OW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else if (len_wr) len_q <= len_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rx_q   <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      lane_q <= '0;
      acc_q  <= '0;
      hold_q <= '0;
      hold_n <= '0;
    end else if (ctl_wr) begin
      en_q <= ctl_en;
      rx_q <= ctl_rx;
      if (ctl_en) begin
        cnt_q  <= len_q;
        done_q <= (len_q == '0);
        lane_q <= '0;
        acc_q  <= '0;
        hold_n <= '0;
      end
    end else begin
      if (en_q && !cnt_nz && empty) en_q <= 1'b0;
      if (in_fire || out_fire) begin
        cnt_q <= cnt_q - LEN_W'(1);
        if (cnt_one) done_q <= 1'b1;
      end
      if (in_fire) begin
        if (last_in) begin
          lane_q <= '0;
          acc_q  <= '0;
        end else begin
          lane_q <= lane_q + 2'd1;
          case (lane_q)
            2'd0:    acc_q[7:0]   <= crd_in_data;
            2'd1:    acc_q[15:8]  <= crd_in_data;
            default: acc_q[23:16] <= crd_in_data;
          endcase
        end
      end
      if (out_fire) begin
        if (hold_n == 3'd0) begin
          hold_q <= {8'd0, head[31:8]};
          hold_n <= 3'd3;
        end else begin
          hold_q <= {8'd0, hold_q[31:8]};
          hold_n <= hold_n - 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/card_byte_bridge_chk.sv
module card_byte_bridge_chk #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic             pop,
  input logic [31:0]      pop_data,
  input logic             crd_in_valid,
  input logic             crd_in_ready,
  input logic             crd_out_valid,
  input logic             crd_out_ready,
  input logic             path_en,
  input logic [LEN_W-1:0] byte_cnt,
  input logic [4:0]       tx_flags,
  input logic [4:0]       rx_flags,
  input logic             xfer_done
);
  a_r4_no_accept_full: assert property (@(posedge clk) disable iff (!rst_n)
    crd_in_ready |-> !rx_flags[3]);

  a_r10_one_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((crd_in_valid && crd_in_ready) || (crd_out_valid && crd_out_ready))
      |=> byte_cnt == $past(byte_cnt) - LEN_W'(1));

  a_r10_single_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(crd_in_ready && crd_out_valid));

  a_r8_one_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    !((tx_flags != 5'd0) && (rx_flags != 5'd0)));

  a_r6_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> byte_cnt == '0);

  a_r5_tx_stops: assert property (@(posedge clk) disable iff (!rst_n)
    crd_out_valid |-> byte_cnt != '0);

  a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(path_en) |-> ($past(ctl_wr) ||
      ($past(byte_cnt) == '0 && $past(tx_flags) == 5'd0 && $past(rx_flags) == 5'd0)));

  a_r9_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && rx_flags[1]) |-> pop_data == 32'd0);
endmodule

bind card_byte_bridge card_byte_bridge_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/card_byte_bridge_tb_top.sv
`timescale 1ns/1ps
module card_byte_bridge_tb_top;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, ctl_en = 0, ctl_rx = 0, len_wr = 0;
  logic [LEN_W-1:0] len_in = '0;
  logic push = 0, pop = 0;
  logic [31:0] push_data = '0, pop_data;
  logic crd_in_valid = 0, crd_in_ready;
  logic [7:0] crd_in_data = '0, crd_out_data;
  logic crd_out_valid, crd_out_ready = 0;
  logic path_en, xfer_done;
  logic [LEN_W-1:0] byte_cnt;
  logic [LEN_W-2:0] word_cnt;
  logic [4:0] tx_flags, rx_flags;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  card_byte_bridge #(.DEPTH(16), .LEN_W(LEN_W)) dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_len(logic [LEN_W-1:0] v);
    @(negedge clk); len_wr = 1; len_in = v;
    @(posedge clk); #1; len_wr = 0;
  endtask

  task automatic wr_ctl(logic en, logic rx);
    @(negedge clk); ctl_wr = 1; ctl_en = en; ctl_rx = rx;
    @(posedge clk); #1; ctl_wr = 0;
  endtask

  task automatic rx_byte(logic [7:0] b);
    @(negedge clk); crd_in_valid = 1; crd_in_data = b; #1;
    chk("R4 ready while room", crd_in_ready, 1);
    @(posedge clk); #1; crd_in_valid = 0;
  endtask

  task automatic bus_pop(output logic [31:0] w);
    @(negedge clk); pop = 1; #1; w = pop_data;
    @(posedge clk); #1; pop = 0;
  endtask

  task automatic bus_push(logic [31:0] w);
    @(negedge clk); push = 1; push_data = w;
    @(posedge clk); #1; push = 0;
  endtask

  task automatic tx_byte(string tag, logic [7:0] exp);
    @(negedge clk); crd_out_ready = 1; #1;
    chk({tag, " valid"}, crd_out_valid, 1);
    chk({tag, " data"}, crd_out_data, exp);
    @(posedge clk); #1; crd_out_ready = 0;
  endtask

  function automatic logic [7:0] pat(int first, int idx);
    return 8'((first + 7 * idx) & 255);
  endfunction

  function automatic logic [31:0] exp_word(int first, int len, int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4 * k + j < len) w[8*j +: 8] = pat(first, 4 * k + j);
    return w;
  endfunction

  localparam logic [23:0] VEC [7] = '{
    {16'd1,  8'h11}, {16'd3,  8'hA0}, {16'd4,  8'h5C}, {16'd7,  8'hF1},
    {16'd9,  8'h30}, {16'd20, 8'h02}, {16'd36, 8'h40}};

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 path_en", path_en, 0);
    chk("R1 byte_cnt", byte_cnt, 0);
    chk("R1 word_cnt", word_cnt, 0);
    chk("R1 tx_flags", tx_flags, 0);
    chk("R1 rx_flags", rx_flags, 0);
    chk("R1 xfer_done", xfer_done, 0);
    @(negedge clk); rst_n = 1;
    bus_pop(w);
    chk("R9 empty pop reads zero", w, 0);

    // R3 R6 R7 R8 receive table
    for (int v = 0; v < 7; v++) begin
      int len   = int'(VEC[v][23:8]);
      int first = int'(VEC[v][7:0]);
      int words = (len + 3) / 4;
      wr_len(LEN_W'(len));
      wr_ctl(1, 1);
      chk("R2 load count", byte_cnt, len);
      chk("R2 word count", word_cnt, words);
      chk("R6 done clear on load", xfer_done, 0);
      for (int i = 0; i < len; i++) rx_byte(pat(first, i));
      chk("R6 done at zero", xfer_done, 1);
      chk("R7 enabled while data queued", path_en, 1);
      chk("R8 rx flags", rx_flags, {words >= 8, words == 16, 1'b1, 1'b0, 1'b1});
      chk("R8 tx flags hidden", tx_flags, 0);
      for (int k = 0; k < words; k++) begin
        bus_pop(w);
        chk("R3 packed word", w, exp_word(first, len, k));
      end
      @(posedge clk); #1;
      chk("R7 self clear", path_en, 0);
      chk("R7 flags zero", rx_flags, 0);
    end

    // R2 R8 long transmit load, word count rounding
    wr_len(16'hFFFF);
    wr_ctl(1, 0);
    chk("R2 word count round", word_cnt, 16384);
    chk("R8 tx empty flags", tx_flags, 5'b10011);
    chk("R8 rx flags hidden", rx_flags, 0);
    wr_ctl(0, 0);
    chk("R7 disable by write", path_en, 0);

    // R4 R10 receive until full
    wr_len(16'd68);
    wr_ctl(1, 1);
    for (int i = 0; i < 3; i++) rx_byte(pat(16, i));
    chk("R10 one step per byte", byte_cnt, 65);
    for (int i = 3; i < 64; i++) rx_byte(pat(16, i));
    chk("R8 rx full flags", rx_flags, 5'b11101);
    @(negedge clk); crd_in_valid = 1; crd_in_data = 8'hEE; #1;
    chk("R4 no ready when full", crd_in_ready, 0);
    @(posedge clk); #1; crd_in_valid = 0;
    chk("R4 count held at full", byte_cnt, 4);
    bus_push(32'h12345678);
    bus_pop(w);
    chk("R3 first word after full", w, exp_word(16, 68, 0));
    for (int i = 64; i < 68; i++) rx_byte(pat(16, i));
    for (int k = 1; k < 17; k++) begin
      bus_pop(w);
      chk("R9 R3 drain word", w, exp_word(16, 68, k));
    end
    @(posedge clk); #1;
    chk("R7 clear after drain", path_en, 0);

    // R5 transmit order and stop at zero
    wr_len(16'd6);
    wr_ctl(1, 0);
    bus_push(32'h44332211);
    bus_push(32'h88776655);
    bus_push(32'hDEADBEEF);
    for (int i = 0; i < 6; i++) tx_byte("R5 tx byte", 8'(8'h11 * (i + 1)));
    @(negedge clk); crd_out_ready = 1; #1;
    chk("R5 stop at zero", crd_out_valid, 0);
    @(posedge clk); #1; crd_out_ready = 0;
    chk("R6 done after tx", xfer_done, 1);
    chk("R8 tx one word left", tx_flags, 5'b10101);
    bus_pop(w);
    chk("R5 untouched third word", w, 32'hDEADBEEF);
    @(posedge clk); #1;
    chk("R7 tx self clear", path_en, 0);

    // R9 push to full FIFO ignored
    wr_len(16'd100);
    wr_ctl(1, 0);
    for (int i = 0; i < 16; i++)
      bus_push({8'((4*i+3) ^ 8'h5A), 8'((4*i+2) ^ 8'h5A), 8'((4*i+1) ^ 8'h5A), 8'((4*i) ^ 8'h5A)});
    chk("R8 tx full flags", tx_flags, 5'b01101);
    bus_push(32'hCAFEF00D);
    for (int k = 0; k < 64; k++) tx_byte("R5 R9 tx stream", 8'(k ^ 8'h5A));
    @(negedge clk); #1;
    chk("R9 extra push dropped", crd_out_valid, 0);
    chk("R10 count after stream", byte_cnt, 36);
    chk("R8 tx drained flags", tx_flags, 5'b10011);
    wr_ctl(0, 0);

    // R6 zero length load
    wr_len(16'd0);
    wr_ctl(1, 0);
    chk("R6 done on zero load", xfer_done, 1);
    chk("R7 enabled for one cycle", path_en, 1);
    chk("R7 flags zero when idle", tx_flags, 0);
    @(posedge clk); #1;
    chk("R7 zero load self clear", path_en, 0);
    chk("R6 done held", xfer_done, 1);
    wr_len(16'd4);
    wr_ctl(1, 1);
    chk("R6 done cleared by load", xfer_done, 0);
    wr_ctl(0, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule